// File: doc/BRIEF.md
# Packed SIMD Saturating DSP Unit

This block is a 32-bit arithmetic datapath for media-style code. It treats each operand as packed lanes, either four unsigned bytes or two signed 16-bit halves, and adds or subtracts them lane by lane. On overflow a lane clamps to the nearest representable value instead of wrapping. It also multiplies signed fractions in Q15 and Q31 format, where values run from -1 up to just below +1. It keeps four 64-bit accumulators for multiply-accumulate work.

Each accepted operation presents an operation code, two 32-bit operands and an accumulator index, and raises `in_valid`. One clock later the 32-bit result appears together with `res_valid`. A four-bit flag vector records, per lane, whether a saturation has occurred. Each flag bit stays set until `flag_clr` is pulsed. Decoding instructions, supplying register operands and writing results back belong to the surrounding pipeline.

Top module: `simd_sat_dsp`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `res` holds its last value while `in_valid` is low. Every operation's result and flag update becomes visible one clock after it is accepted.
- R2: Op 0 adds and op 1 subtracts the four unsigned byte lanes, where lane i is bits 8i+7..8i. A sum above 255 gives 255, a difference below 0 gives 0, and each case sets flag bit i.
- R3: Op 2 adds and op 3 subtracts the two signed 16-bit lanes, where lane i is bits 16i+15..16i. A result above 32767 gives 0x7FFF, a result below -32768 gives 0x8000, and each case sets flag bit i.
- R4: Op 8 adds the two 16-bit lanes modulo 2^16 and never sets a flag.
- R5: Op 4 multiplies the two 16-bit lanes as Q15 values. The lane result is bits 30..15 of the signed 32-bit product. The case 0x8000 × 0x8000 returns 0x7FFF and sets flag bit i.
- R6: Op 5 multiplies the full operands as Q31 values and returns bits 62..31 of the signed 64-bit product. The case 0x80000000 × 0x80000000 returns 0x7FFFFFFF and sets flag bit 0.
- R7: Op 6 adds both signed 16×16 lane products, sign-extended to 64 bits, to the accumulator selected by `acc_sel`. The sum wraps modulo 2^64. The result is the new upper 32 bits of that accumulator, and the other accumulators do not change.
- R8: Op 7 adds the Q31 product shifted left by one to the selected accumulator and returns the new upper word. The case 0x80000000 × 0x80000000 adds 0x7FFFFFFFFFFFFFFF and sets flag bit 0.
- R9: Op 9 returns the upper word and op 10 the lower word of the selected accumulator as it stood before the operation. Op 11 zeroes the selected accumulator and returns 0. Codes 12 to 15 return 0.
- R10: Flag bits are sticky. `flag_clr` zeroes them, but a saturation by an operation accepted in the same cycle still sets its bit.
- R11: After reset, `res_valid`, `res` and the flags are 0, and all four accumulators read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 4 | Operation code |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand |
| acc_sel | input | 2 | Accumulator index |
| flag_clr | input | 1 | Clear sticky lane flags |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res | output | 32 | Registered result |
| lane_ovf | output | 4 | Sticky per-lane saturation flags |

## Verification
Two things can happen on the same edge: a flag clear and a saturating operation that sets a flag. The bench provokes this both with directed cases and with random clears mixed into the random traffic. It expects the new saturation bits to survive and the older bits to vanish. A multiply-accumulate followed at once by a read of the same accumulator is also driven back to back. The read must show the updated value, while reads of other accumulators must show them untouched.

// File: rtl/simd_sat_dsp.sv
module simd_sat_dsp #(
  parameter int ACC_N = 4,
  localparam int SEL_W = $clog2(ACC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       op,
  input  logic [31:0]      opa,
  input  logic [31:0]      opb,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic             flag_clr,
  output logic             res_valid,
  output logic [31:0]      res,
  output logic [3:0]       lane_ovf
);

  localparam logic [3:0] OP_ADDQB  = 4'd0;
  localparam logic [3:0] OP_SUBQB  = 4'd1;
  localparam logic [3:0] OP_ADDPH  = 4'd2;
  localparam logic [3:0] OP_SUBPH  = 4'd3;
  localparam logic [3:0] OP_MULQ15 = 4'd4;
  localparam logic [3:0] OP_MULQ31 = 4'd5;
  localparam logic [3:0] OP_MACPH  = 4'd6;
  localparam logic [3:0] OP_MACQ31 = 4'd7;
  localparam logic [3:0] OP_ADDPHW = 4'd8;
  localparam logic [3:0] OP_RDHI   = 4'd9;
  localparam logic [3:0] OP_RDLO   = 4'd10;
  localparam logic [3:0] OP_CLRACC = 4'd11;

  function automatic logic [8:0] addu8(input logic [7:0] a, input logic [7:0] b, input logic sub);
    logic [8:0] s;
    s = sub ? {1'b0, a} - {1'b0, b} : {1'b0, a} + {1'b0, b};
    if (!s[8]) return s;
    return sub ? 9'h100 : 9'h1ff;
  endfunction

  function automatic logic [16:0] adds16(input logic [15:0] a, input logic [15:0] b, input logic sub);
    logic [16:0] s;
    s = sub ? {a[15], a} - {b[15], b} : {a[15], a} + {b[15], b};
    if (s[16] == s[15]) return {1'b0, s[15:0]};
    return {1'b1, s[16] ? 16'h8000 : 16'h7fff};
  endfunction

  function automatic logic [16:0] mulq15(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p;
    if (a == 16'h8000 && b == 16'h8000) return {1'b1, 16'h7fff};
    p = $signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b});
    return {1'b0, p[30:15]};
  endfunction

  logic [63:0] acc [ACC_N];
  logic [63:0] acc_cur, acc_nx, q31_add;
  logic [31:0] p0, p1, r;
  logic [63:0] pq;
  logic [8:0]  t9;
  logic [16:0] t17;
  logic [3:0]  ov;
  logic        acc_we, q31_ov;

  assign acc_cur = acc[acc_sel];
  assign p0 = $signed({{16{opa[15]}}, opa[15:0]}) * $signed({{16{opb[15]}}, opb[15:0]});
  assign p1 = $signed({{16{opa[31]}}, opa[31:16]}) * $signed({{16{opb[31]}}, opb[31:16]});
  assign pq = $signed({{32{opa[31]}}, opa}) * $signed({{32{opb[31]}}, opb});
  assign q31_ov  = (opa == 32'h8000_0000) && (opb == 32'h8000_0000);
  assign q31_add = q31_ov ? 64'h7fff_ffff_ffff_ffff : {pq[62:0], 1'b0};

  always_comb begin
    r = '0;
    ov = '0;
    t9 = '0;
    t17 = '0;
    acc_we = 1'b0;
    acc_nx = acc_cur;
    case (op)
      OP_ADDQB, OP_SUBQB:
        for (int i = 0; i < 4; i++) begin
          t9 = addu8(opa[8*i +: 8], opb[8*i +: 8], op == OP_SUBQB);
          r[8*i +: 8] = t9[7:0];
          ov[i] = t9[8];
        end
      OP_ADDPH, OP_SUBPH:
        for (int i = 0; i < 2; i++) begin
          t17 = adds16(opa[16*i +: 16], opb[16*i +: 16], op == OP_SUBPH);
          r[16*i +: 16] = t17[15:0];
          ov[i] = t17[16];
        end
      OP_MULQ15:
        for (int i = 0; i < 2; i++) begin
          t17 = mulq15(opa[16*i +: 16], opb[16*i +: 16]);
          r[16*i +: 16] = t17[15:0];
          ov[i] = t17[16];
        end
      OP_ADDPHW: r = {opa[31:16] + opb[31:16], opa[15:0] + opb[15:0]};
      OP_MULQ31: begin
        r = q31_ov ? 32'h7fff_ffff : pq[62:31];
        ov[0] = q31_ov;
      end
      OP_MACPH: begin
        acc_nx = acc_cur + {{32{p0[31]}}, p0} + {{32{p1[31]}}, p1};
        acc_we = 1'b1;
        r = acc_nx[63:32];
      end
      OP_MACQ31: begin
        acc_nx = acc_cur + q31_add;
        acc_we = 1'b1;
        ov[0] = q31_ov;
        r = acc_nx[63:32];
      end
      OP_RDHI: r = acc_cur[63:32];
      OP_RDLO: r = acc_cur[31:0];
      OP_CLRACC: begin
        acc_nx = '0;
        acc_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res <= '0;
      lane_ovf <= '0;
      for (int k = 0; k < ACC_N; k++) acc[k] <= '0;
    end else begin
      res_valid <= in_valid;
      lane_ovf <= (flag_clr ? 4'b0 : lane_ovf) | (in_valid ? ov : 4'b0);
      if (in_valid) begin
        res <= r;
        if (acc_we) acc[acc_sel] <= acc_nx;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(in_valid));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((lane_ovf & $past(lane_ovf)) == $past(lane_ovf)));

  a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !in_valid) |=> lane_ovf == 4'b0);

  a_r5_q15_corner: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_MULQ15 && opa[15:0] == 16'h8000 && opb[15:0] == 16'h8000)
    |=> (res[15:0] == 16'h7fff && lane_ovf[0]));

  a_r6_q31_corner: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_MULQ31 && opa == 32'h8000_0000 && opb == 32'h8000_0000)
    |=> (res == 32'h7fff_ffff && lane_ovf[0]));

  a_r4_wrap_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ADDPHW && !flag_clr) |=> lane_ovf == $past(lane_ovf));

  for (genvar g = 0; g < 4; g++) begin : g_byte_chk
    a_r2_add_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_ADDQB) |=> res[8*g +: 8] >= $past(opa[8*g +: 8]));
    a_r2_sub_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_SUBQB) |=> res[8*g +: 8] <= $past(opa[8*g +: 8]));
  end

endmodule

// File: tb/simd_sat_dsp_tb.sv
`timescale 1ns/1ps
module simd_sat_dsp_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, in_valid, flag_clr, res_valid;
  logic [3:0]  op, lane_ovf;
  logic [31:0] opa, opb, res;
  logic [1:0]  acc_sel;

  simd_sat_dsp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .acc_sel(acc_sel), .flag_clr(flag_clr), .res_valid(res_valid), .res(res),
    .lane_ovf(lane_ovf)
  );

  int total = 0, bad = 0;
  logic [63:0] macc [4];
  logic [3:0]  m_ovf;
  logic [31:0] last_res;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] s, input logic c, input string tag);
    logic [31:0] er;
    logic [3:0]  eo;
    er = '0;
    eo = '0;
    case (o)
      4'd0, 4'd1:
        for (int i = 0; i < 4; i++) begin
          int x, y, t;
          x = int'(a[8*i +: 8]);
          y = int'(b[8*i +: 8]);
          t = (o == 4'd0) ? x + y : x - y;
          if (t > 255) begin er[8*i +: 8] = 8'hff; eo[i] = 1'b1; end
          else if (t < 0) begin er[8*i +: 8] = 8'h00; eo[i] = 1'b1; end
          else er[8*i +: 8] = t[7:0];
        end
      4'd2, 4'd3:
        for (int i = 0; i < 2; i++) begin
          shortint hx, hy;
          int t;
          hx = a[16*i +: 16];
          hy = b[16*i +: 16];
          t = (o == 4'd2) ? int'(hx) + int'(hy) : int'(hx) - int'(hy);
          if (t > 32767) begin er[16*i +: 16] = 16'h7fff; eo[i] = 1'b1; end
          else if (t < -32768) begin er[16*i +: 16] = 16'h8000; eo[i] = 1'b1; end
          else er[16*i +: 16] = t[15:0];
        end
      4'd8:
        for (int i = 0; i < 2; i++) er[16*i +: 16] = a[16*i +: 16] + b[16*i +: 16];
      4'd4:
        for (int i = 0; i < 2; i++) begin
          shortint hx, hy;
          int p;
          hx = a[16*i +: 16];
          hy = b[16*i +: 16];
          if (hx == -32768 && hy == -32768) begin er[16*i +: 16] = 16'h7fff; eo[i] = 1'b1; end
          else begin p = int'(hx) * int'(hy); p = p >>> 15; er[16*i +: 16] = p[15:0]; end
        end
      4'd5, 4'd7: begin
        int sa, sb;
        longint p;
        logic [63:0] add;
        sa = a;
        sb = b;
        p = longint'(sa) * longint'(sb);
        if (a == 32'h8000_0000 && b == 32'h8000_0000) begin
          eo[0] = 1'b1;
          er = 32'h7fff_ffff;
          add = 64'h7fff_ffff_ffff_ffff;
        end else begin
          longint q;
          q = p >>> 31;
          er = q[31:0];
          add = p <<< 1;
        end
        if (o == 4'd7) begin
          macc[s] = macc[s] + add;
          er = macc[s][63:32];
        end
      end
      4'd6: begin
        shortint x0, y0, x1, y1;
        longint q0, q1;
        x0 = a[15:0]; y0 = b[15:0]; x1 = a[31:16]; y1 = b[31:16];
        q0 = longint'(x0) * longint'(y0);
        q1 = longint'(x1) * longint'(y1);
        macc[s] = macc[s] + q0 + q1;
        er = macc[s][63:32];
      end
      4'd9:  er = macc[s][63:32];
      4'd10: er = macc[s][31:0];
      4'd11: begin macc[s] = '0; er = '0; end
      default: er = '0;
    endcase
    m_ovf = (c ? 4'b0 : m_ovf) | eo;
    in_valid = 1'b1; op = o; opa = a; opb = b; acc_sel = s; flag_clr = c;
    @(negedge clk);
    check({tag, " valid (R1)"}, {63'b0, res_valid}, 64'd1);
    check({tag, " res"}, {32'b0, res}, {32'b0, er});
    check({tag, " flags (R10)"}, {60'b0, lane_ovf}, {60'b0, m_ovf});
    last_res = er;
  endtask

  task automatic idle(input logic c);
    if (c) m_ovf = 4'b0;
    in_valid = 1'b0; flag_clr = c; opa = $urandom; opb = $urandom; op = 4'd0;
    @(negedge clk);
    check("R1 idle valid", {63'b0, res_valid}, 64'd0);
    check("R1 idle hold", {32'b0, res}, {32'b0, last_res});
    check("R10 idle flags", {60'b0, lane_ovf}, {60'b0, m_ovf});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h8000_8000;
      1: return 32'h7fff_7fff;
      2: return 32'hffff_ffff;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  logic finished = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) macc[k] = '0;
    m_ovf = '0; last_res = '0;
    rst_n = 1'b0; in_valid = 1'b0; flag_clr = 1'b0; op = '0; opa = '0; opb = '0; acc_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset valid", {63'b0, res_valid}, 64'd0);
    check("R11 reset res", {32'b0, res}, 64'd0);
    check("R11 reset flags", {60'b0, lane_ovf}, 64'd0);
    for (int k = 0; k < 4; k++) begin
      issue(4'd9, 0, 0, 2'(k), 1'b0, "R11 acc hi");
      issue(4'd10, 0, 0, 2'(k), 1'b0, "R11 acc lo");
    end

    issue(4'd0, 32'hf0_10_ff_01, 32'h20_10_01_02, 0, 1'b0, "R2 byte add sat");
    issue(4'd1, 32'h05_80_00_ff, 32'h06_01_01_ff, 0, 1'b1, "R2 byte sub floor");
    issue(4'd2, 32'h7fff_8000, 32'h0001_ffff, 0, 1'b1, "R3 half add sat");
    issue(4'd3, 32'h8000_7fff, 32'h0001_ffff, 0, 1'b1, "R3 half sub sat");
    issue(4'd8, 32'h7fff_ffff, 32'h0001_0001, 0, 1'b1, "R4 half wrap");
    issue(4'd4, 32'h4000_8000, 32'h4000_8000, 0, 1'b1, "R5 q15 corner");
    issue(4'd4, 32'hc000_2000, 32'h4000_6000, 0, 1'b1, "R5 q15 normal");
    issue(4'd5, 32'h8000_0000, 32'h8000_0000, 0, 1'b1, "R6 q31 corner");
    issue(4'd5, 32'h4000_0000, 32'hc000_0000, 0, 1'b0, "R6 q31 normal");
    issue(4'd6, 32'h7fff_8000, 32'h7fff_8000, 2, 1'b0, "R7 mac acc2");
    issue(4'd10, 0, 0, 2, 1'b0, "R7 read acc2 lo");
    issue(4'd9, 0, 0, 1, 1'b0, "R7 other acc untouched");
    issue(4'd7, 32'h8000_0000, 32'h8000_0000, 3, 1'b0, "R8 macq31 corner");
    issue(4'd10, 0, 0, 3, 1'b0, "R8 read lo");
    issue(4'd11, 0, 0, 3, 1'b0, "R9 clear acc3");
    issue(4'd9, 0, 0, 3, 1'b0, "R9 read cleared");
    issue(4'd13, 32'h1234_5678, 32'h1, 0, 1'b0, "R9 unused code");
    issue(4'd0, 32'hff_00_00_00, 32'h01_00_00_00, 0, 1'b1, "R10 clear with new sat");
    idle(1'b0);
    idle(1'b1);

    for (int n = 0; n < 600; n++) begin
      logic [3:0] o;
      o = 4'($urandom % 14);
      if ($urandom % 5 == 0) idle(($urandom % 4) == 0);
      issue(o, pick(), pick(), 2'($urandom % 4), ($urandom % 8) == 0, "R1-random");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule